// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences the two instruction-triggered power-save states of a small processor core. The instruction decoder sends it a single-cycle save request whose operand picks one of two states. In the light state (Idle) the core stops while the peripheral clock and the main oscillator keep running. In the deep state (Sleep) the core clock, the peripheral clock and the main oscillator are all gated off. The clock-failure monitor is held in suspend, and the low-rate watchdog clock stays on only when the watchdog is enabled.

Entering Sleep with the watchdog enabled sends a clear strobe to the watchdog in the request cycle. Either state ends on an enabled interrupt, a watchdog time-out or a device reset, and the controller then returns to Run. The clock-source selection is captured when the request is accepted. It is held while the core is stopped and is driven back out on wake-up, so the core restarts on the source it was using before. The block does not model the oscillators, the watchdog counter, interrupt priority or clock division.

Top module: `lp_mode_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, mode_o is 2'b00 (Run), all three clock enables and lprc_en_o are 1, mon_susp_o, wdt_clr_o and wake_irq_o are 0, and clk_sel_o is 0.
- R2: In Run, a save_req_i pulse with save_sleep_i=0 and no wake event gives mode_o=2'b01 (Idle) from the next cycle. In Idle cpu_clk_en_o is 0, and per_clk_en_o and osc_en_o stay 1.
- R3: In Run, a save_req_i pulse with save_sleep_i=1 and no wake event gives mode_o=2'b10 (Sleep) from the next cycle. In Sleep cpu_clk_en_o, per_clk_en_o and osc_en_o are all 0.
- R4: wdt_clr_o is 1 only in the Run cycle that carries an accepted Sleep request while wdt_en_i is 1. An Idle request never raises it.
- R5: lprc_en_o is 1 in Run and Idle. In Sleep it equals wdt_en_i.
- R6: mon_susp_o is 1 exactly while mode_o is Sleep.
- R7: In Idle or Sleep, irq_i, wdt_to_i or soft_rst_i returns mode_o to Run on the next cycle.
- R8: wake_irq_o is 1 for exactly the first Run cycle after a wake in which irq_i was present and soft_rst_i was not. Otherwise it is 0.
- R9: A wake event (irq_i, wdt_to_i or soft_rst_i) in the same cycle as save_req_i cancels the entry. mode_o stays Run and wdt_clr_o stays 0.
- R10: In Run, clk_sel_o follows clk_sel_i one cycle later. From an accepted request until the first Run cycle after wake-up, clk_sel_o holds the clk_sel_i value of the request cycle, whatever clk_sel_i does.
- R11: soft_rst_i during Idle or Sleep forces Run, keeps the held clk_sel_o value for that first Run cycle, and gives wake_irq_o=0 even if irq_i is also present.
- R12: save_req_i in Idle or Sleep without a wake event is ignored: mode_o and all enables are unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| save_req_i | input | 1 | Single-cycle power-save request from the decoder |
| save_sleep_i | input | 1 | Request operand: 1 Sleep, 0 Idle |
| wdt_en_i | input | 1 | Watchdog enabled |
| irq_i | input | 1 | An individually enabled interrupt is pending |
| wdt_to_i | input | 1 | Watchdog time-out |
| soft_rst_i | input | 1 | Synchronous device reset from any non-power-on source |
| clk_sel_i | input | SEL_W | Currently active clock-source selection |
| mode_o | output | 2 | 00 Run, 01 Idle, 10 Sleep |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| lprc_en_o | output | 1 | Low-rate watchdog clock enable |
| mon_susp_o | output | 1 | Clock-failure monitor suspend |
| wdt_clr_o | output | 1 | Watchdog clear strobe |
| wake_irq_o | output | 1 | Single-cycle flag marking an interrupt wake |
| clk_sel_o | output | SEL_W | Clock-source selection to apply |

## Verification
The mode, the enables derived from it, the wake flag and clk_sel_o change one clock edge after the cycle that carries the request or the wake event. wdt_clr_o is combinational and must appear in the request cycle itself. The bench drives each cycle's inputs on the falling edge and compares every output one time step later against a behavioural model. Before the next rising edge the model is moved on by one step, so each registered result is checked in the cycle after its cause and each combinational one in the same cycle.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_SLEEP = 2'b10
  } lp_mode_e;
endpackage

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     save_req_i,
  input  logic     save_sleep_i,
  input  logic     irq_i,
  input  logic     wdt_to_i,
  input  logic     soft_rst_i,
  output lp_mode_e mode_o,
  output logic     wake_irq_o
);
  lp_mode_e mode_q, mode_d;
  logic     wake_irq_q, wake_irq_d;
  logic     wake;

  assign wake = irq_i | wdt_to_i | soft_rst_i;

  always_comb begin
    mode_d     = mode_q;
    wake_irq_d = 1'b0;
    if (mode_q == MODE_RUN) begin
      // a coincident wake event cancels entry
      if (save_req_i && !wake) mode_d = save_sleep_i ? MODE_SLEEP : MODE_IDLE;
    end else if (wake) begin
      mode_d     = MODE_RUN;
      wake_irq_d = irq_i & ~soft_rst_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_RUN;
      wake_irq_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      wake_irq_q <= wake_irq_d;
    end
  end

  assign mode_o     = mode_q;
  assign wake_irq_o = wake_irq_q;

  a_r2_idle_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && save_req_i && !save_sleep_i && !wake) |=> mode_q == MODE_IDLE);
  a_r3_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && save_req_i && save_sleep_i && !wake) |=> mode_q == MODE_SLEEP);
  a_r7_wake_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_RUN && wake) |=> mode_q == MODE_RUN);
  a_r9_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && wake) |=> mode_q == MODE_RUN);
  a_r8_flag_on_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_irq_q) |-> (mode_q == MODE_RUN && $past(mode_q) != MODE_RUN));
  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_q |=> !wake_irq_q);
  a_r12_ignore_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_RUN && !wake) |=> $stable(mode_q));
endmodule

// File: rtl/lp_sel_hold.sv
module lp_sel_hold #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             track_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  // device resets leave the stored selection alone; only power-on clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (track_i) sel_q <= sel_i;
  end

  assign sel_o = sel_q;

  a_r10_hold_while_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !track_i |=> $stable(sel_q));
endmodule

// File: rtl/lp_clk_gate.sv
module lp_clk_gate
  import lp_pkg::*;
(
  input  lp_mode_e mode_i,
  input  logic     save_req_i,
  input  logic     save_sleep_i,
  input  logic     wake_i,
  input  logic     wdt_en_i,
  output logic     cpu_clk_en_o,
  output logic     per_clk_en_o,
  output logic     osc_en_o,
  output logic     lprc_en_o,
  output logic     mon_susp_o,
  output logic     wdt_clr_o
);
  logic asleep;

  assign asleep       = (mode_i == MODE_SLEEP);
  assign cpu_clk_en_o = (mode_i == MODE_RUN);
  assign per_clk_en_o = ~asleep;
  assign osc_en_o     = ~asleep;
  assign lprc_en_o    = ~asleep | wdt_en_i;
  assign mon_susp_o   = asleep;
  // clear lands in the request cycle, before the mode register flips
  assign wdt_clr_o    = (mode_i == MODE_RUN) & save_req_i & save_sleep_i & wdt_en_i & ~wake_i;
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_req_i,
  input  logic             save_sleep_i,
  input  logic             wdt_en_i,
  input  logic             irq_i,
  input  logic             wdt_to_i,
  input  logic             soft_rst_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  output logic [1:0]       mode_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic             lprc_en_o,
  output logic             mon_susp_o,
  output logic             wdt_clr_o,
  output logic             wake_irq_o,
  output logic [SEL_W-1:0] clk_sel_o
);
  lp_mode_e mode;
  logic     wake;

  assign wake   = irq_i | wdt_to_i | soft_rst_i;
  assign mode_o = mode;

  lp_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .save_req_i  (save_req_i),
    .save_sleep_i(save_sleep_i),
    .irq_i       (irq_i),
    .wdt_to_i    (wdt_to_i),
    .soft_rst_i  (soft_rst_i),
    .mode_o      (mode),
    .wake_irq_o  (wake_irq_o)
  );

  lp_sel_hold #(.SEL_W(SEL_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .track_i(mode == MODE_RUN),
    .sel_i  (clk_sel_i),
    .sel_o  (clk_sel_o)
  );

  lp_clk_gate u_gate (
    .mode_i      (mode),
    .save_req_i  (save_req_i),
    .save_sleep_i(save_sleep_i),
    .wake_i      (wake),
    .wdt_en_i    (wdt_en_i),
    .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o),
    .osc_en_o    (osc_en_o),
    .lprc_en_o   (lprc_en_o),
    .mon_susp_o  (mon_susp_o),
    .wdt_clr_o   (wdt_clr_o)
  );

  a_r4_clr_precedes_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> mode_o == 2'b10);
  a_r3_sleep_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10) |-> !(cpu_clk_en_o | per_clk_en_o | osc_en_o));
  a_r6_monitor_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mon_susp_o) |-> $past(wdt_clr_o | (save_req_i & save_sleep_i)));
  a_r5_lprc_when_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_clk_en_o |-> lprc_en_o);
endmodule

// File: tb/lp_mode_ctrl_bench.sv
module lp_mode_ctrl_bench;
  localparam int SEL_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic save_req = 0, save_sleep = 0, wdt_en = 0, irq = 0, wdt_to = 0, soft_rst = 0;
  logic [SEL_W-1:0] clk_sel = '0;
  logic [1:0] mode;
  logic cpu_en, per_en, osc_en, lprc_en, mon_susp, wdt_clr, wake_irq;
  logic [SEL_W-1:0] sel_out;

  int n_tests = 0, n_fail = 0;
  int m_mode = 0, m_sel = 0, m_wirq = 0;

  always #5 clk = ~clk;

  lp_mode_ctrl #(.SEL_W(SEL_W)) u_lp_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .save_req_i(save_req), .save_sleep_i(save_sleep),
    .wdt_en_i(wdt_en), .irq_i(irq), .wdt_to_i(wdt_to), .soft_rst_i(soft_rst),
    .clk_sel_i(clk_sel), .mode_o(mode), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .osc_en_o(osc_en), .lprc_en_o(lprc_en), .mon_susp_o(mon_susp), .wdt_clr_o(wdt_clr),
    .wake_irq_o(wake_irq), .clk_sel_o(sel_out)
  );

  task automatic chk(string tag, string scn, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual %0d expected %0d", tag, scn, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare, then step the model
  task automatic cyc(string scn, bit rq, bit sl, bit we, bit ir, bit wt, bit sr, int sel);
    int wake;
    @(negedge clk);
    save_req = rq; save_sleep = sl; wdt_en = we; irq = ir; wdt_to = wt; soft_rst = sr;
    clk_sel = SEL_W'(sel);
    #1;
    wake = (ir || wt || sr) ? 1 : 0;
    chk("R7",  scn, int'(mode), m_mode);
    chk("R2",  scn, int'(cpu_en), (m_mode == 0) ? 1 : 0);
    chk("R3",  scn, int'(per_en), (m_mode != 2) ? 1 : 0);
    chk("R3",  scn, int'(osc_en), (m_mode != 2) ? 1 : 0);
    chk("R5",  scn, int'(lprc_en), (m_mode != 2 || we) ? 1 : 0);
    chk("R6",  scn, int'(mon_susp), (m_mode == 2) ? 1 : 0);
    chk("R4",  scn, int'(wdt_clr), (m_mode == 0 && rq && sl && we && wake == 0) ? 1 : 0);
    chk("R8",  scn, int'(wake_irq), m_wirq);
    chk("R10", scn, int'(sel_out), m_sel);
    if (m_mode == 0) begin
      m_sel  = sel;
      m_wirq = 0;
      if (rq && wake == 0) m_mode = sl ? 2 : 1;
    end else begin
      m_wirq = (ir && !sr) ? 1 : 0;
      if (wake != 0) m_mode = 0;
    end
  endtask

  initial begin
    fork
      begin
        #3;
        chk("R1", "reset", int'(mode), 0);
        chk("R1", "reset", int'(cpu_en & per_en & osc_en & lprc_en), 1);
        chk("R1", "reset", int'(mon_susp | wdt_clr | wake_irq), 0);
        chk("R1", "reset", int'(sel_out), 0);
        @(negedge clk); @(negedge clk);
        rst_ni = 1'b1;
        // R1 / R10: run with tracking selection
        cyc("R1", 0,0,1,0,0,0, 1);
        cyc("R10", 0,0,1,0,0,0, 2);
        cyc("R10", 0,0,1,0,0,0, 3);
        // R2: idle entry, wdt enabled but no clear, interrupt wake
        cyc("R2", 1,0,1,0,0,0, 4);
        cyc("R2", 0,0,1,0,0,0, 6);
        cyc("R2", 0,0,1,0,0,0, 7);
        cyc("R8", 0,0,1,1,0,0, 7);
        cyc("R8", 0,0,1,0,0,0, 1);
        cyc("R8", 0,0,1,0,0,0, 1);
        // R3/R4/R5/R6: sleep with watchdog, selection changes, wdt wake
        cyc("R4", 1,1,1,0,0,0, 5);
        cyc("R5", 0,0,1,0,0,0, 0);
        cyc("R10", 0,0,1,0,0,0, 2);
        cyc("R7", 0,0,1,0,1,0, 3);
        cyc("R10", 0,0,1,0,0,0, 3);
        cyc("R10", 0,0,1,0,0,0, 3);
        // sleep with watchdog off
        cyc("R5", 1,1,0,0,0,0, 6);
        cyc("R5", 0,0,0,0,0,0, 1);
        cyc("R8", 0,0,0,1,1,0, 1);
        cyc("R8", 0,0,0,0,0,0, 2);
        // R9: coincident wake cancels entry
        cyc("R9", 1,1,1,1,0,0, 2);
        cyc("R9", 1,1,1,0,1,0, 2);
        cyc("R9", 1,0,1,0,0,1, 2);
        cyc("R9", 0,0,1,0,0,0, 2);
        // R11: soft reset exits sleep, suppresses flag, keeps selection
        cyc("R11", 1,1,1,0,0,0, 4);
        cyc("R11", 0,0,1,0,0,0, 0);
        cyc("R11", 0,0,1,1,0,1, 0);
        cyc("R11", 0,0,1,0,0,0, 5);
        cyc("R11", 0,0,1,0,0,0, 5);
        // R12: request while idle is ignored
        cyc("R12", 1,0,0,0,0,0, 3);
        cyc("R12", 1,1,1,0,0,0, 3);
        cyc("R12", 1,0,1,0,0,0, 3);
        cyc("R12", 0,0,1,0,0,1, 3);
        cyc("R12", 0,0,1,0,0,0, 3);
        // back-to-back sleep after interrupt wake
        cyc("R8", 1,1,1,0,0,0, 7);
        cyc("R8", 0,0,1,1,0,0, 0);
        cyc("R8", 1,1,1,0,0,0, 1);
        cyc("R8", 0,0,1,0,0,0, 2);
        cyc("R8", 0,0,1,1,0,0, 2);
        cyc("R8", 0,0,1,0,0,0, 2);
      end
      begin
        repeat (2000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule